// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two K-digit signed-digit numbers, each digit being -1, 0 or +1, and returns a (K+1)-digit signed-digit sum. No carry ripples across the word. Each stage only rewrites pairs of neighbouring digits, so the delay is the same for any width K. The work is split over three registered stages. The first stage splits each digit-pair sum into a transfer digit, which moves one place up, and an interim digit. The second stage repeats the split on the aligned vectors, using a rule that never lets a transfer leave the top digit. The third stage adds the last interim and transfer vectors digit by digit.

A producer presents an operand pair together with a valid strobe. The result comes out with its own valid strobe exactly three clock cycles later. A new pair may be presented in every cycle, so streams of additions run at full rate. When no pair is offered, the result bus keeps the last sum it produced.

Top module: `sdadd_carry_free`

## Requirements
- R1: While reset is asserted and after it is released, before any valid pair has arrived, valid_o is 0 and every digit of sum_o is 00.
- R2: Digit i of sum_o has weight 2^i. The value of sum_o equals the value of a_i plus the value of b_i for every combination of operand digits, and the result has K+1 digits.
- R3: valid_o equals valid_i from exactly three clock cycles earlier. When valid_o is 1, sum_o holds the sum of the pair that was presented in that cycle.
- R4: A new operand pair is accepted in every cycle with no stall. Pairs presented in consecutive cycles give results in consecutive cycles, in the same order.
- R5: Digits are coded in 2 bits: 00 means 0, 01 means +1 and 11 means -1. The code 10 never appears on sum_o while valid_o is 1. An input digit coded 10 is taken as 0.
- R6: The second stage never produces a transfer out of its most significant digit position.
- R7: In the final stage, the interim digit plus the incoming transfer digit always lies within {-1, 0, +1}, so no digit saturates.
- R8: While valid_i is 0, sum_o keeps its last value, and valid_o is 0 three cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair is valid in this cycle |
| a_i | input | 2*K | First operand, K signed digits, digit 0 in bits 1:0 |
| b_i | input | 2*K | Second operand, K signed digits, digit 0 in bits 1:0 |
| valid_o | output | 1 | sum_o holds a new result |
| sum_o | output | 2*(K+1) | Sum, K+1 signed digits, digit 0 in bits 1:0 |

## Verification
In steady streaming, one result leaves the last stage in the same cycle that a new pair enters the first stage, and the middle stage is working on a third pair. Any mix-up between stages would therefore corrupt a neighbouring addition. The bench drives a new pair in every cycle, covering all 6561 pairs for K=4 and random pairs with random gaps for K=16. Each result is judged against the integer sum of the pair presented three cycles earlier, and the valid strobe is checked in every cycle. In idle cycles the operands keep changing, and the bench checks that the held result does not move.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
  typedef logic [1:0] sd_t;

  localparam sd_t SD_ZERO = 2'b00;
  localparam sd_t SD_POS  = 2'b01;
  localparam sd_t SD_NEG  = 2'b11;

  // 10 is not a legal code; it decodes as zero
  function automatic logic signed [2:0] sd_val(sd_t d);
    case (d)
      SD_POS:  return 3'sd1;
      SD_NEG:  return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic sd_t sd_enc(logic signed [2:0] v);
    if (v > 3'sd0) return SD_POS;
    if (v < 3'sd0) return SD_NEG;
    return SD_ZERO;
  endfunction
endpackage

// File: rtl/sdadd_split.sv
module sdadd_split
  import sdadd_pkg::*;
#(
  parameter int K = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2*K-1:0]   a_i,
  input  logic [2*K-1:0]   b_i,
  output logic             valid_o,
  output logic [2*K+1:0]   xfer_o,
  output logic [2*K+1:0]   intr_o
);
  logic [2*K+1:0] xfer_d, intr_d;

  // transfer vector shifts up one place, interim gets a zero on top
  assign xfer_d[1:0]         = SD_ZERO;
  assign intr_d[2*K+1:2*K]   = SD_ZERO;

  for (genvar i = 0; i < K; i++) begin : g_dig
    logic signed [2:0] s;
    assign s = sd_val(a_i[2*i+:2]) + sd_val(b_i[2*i+:2]);
    assign xfer_d[2*(i+1)+:2] = sd_enc(s);
    assign intr_d[2*i+:2]     = (s == 3'sd1)  ? SD_NEG :
                                (s == -3'sd1) ? SD_POS : SD_ZERO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      xfer_o  <= '0;
      intr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        xfer_o <= xfer_d;
        intr_o <= intr_d;
      end
    end
  end
endmodule

// File: rtl/sdadd_merge.sv
module sdadd_merge
  import sdadd_pkg::*;
#(
  parameter int K = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2*K+1:0]   xfer_i,
  input  logic [2*K+1:0]   intr_i,
  output logic             valid_o,
  output logic [2*K+1:0]   xfer_o,
  output logic [2*K+1:0]   intr_o
);
  localparam int ND = K + 1;

  logic [2*ND+1:0] tr_all;
  logic [2*K+1:0]  intr_d;
  sd_t             top_tr;

  assign tr_all[1:0] = SD_ZERO;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic signed [2:0] s;
    logic              big;
    assign s   = sd_val(intr_i[2*i+:2]) + sd_val(xfer_i[2*i+:2]);
    assign big = (s == 3'sd2) || (s == -3'sd2);
    // transfer only on +-2, so the interim stays in range
    assign tr_all[2*(i+1)+:2] = big ? sd_enc(s) : SD_ZERO;
    assign intr_d[2*i+:2]     = big ? SD_ZERO : sd_enc(s);
  end

  assign top_tr = tr_all[2*ND+1:2*ND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      xfer_o  <= '0;
      intr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        xfer_o <= tr_all[2*K+1:0];
        intr_o <= intr_d;
      end
    end
  end

  AST_TOP_XFER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> top_tr == SD_ZERO); // R6
endmodule

// File: rtl/sdadd_join.sv
module sdadd_join
  import sdadd_pkg::*;
#(
  parameter int K = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2*K+1:0]   xfer_i,
  input  logic [2*K+1:0]   intr_i,
  output logic             valid_o,
  output logic [2*K+1:0]   sum_o
);
  localparam int ND = K + 1;

  logic [2*K+1:0] sum_d;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic signed [2:0] raw;
    assign raw = sd_val(intr_i[2*i+:2]) + sd_val(xfer_i[2*i+:2]);
    assign sum_d[2*i+:2] = sd_enc(raw);

    AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> (raw <= 3'sd1 && raw >= -3'sd1)); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sum_o <= sum_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o)); // R8
endmodule

// File: rtl/sdadd_carry_free.sv
module sdadd_carry_free
  import sdadd_pkg::*;
#(
  parameter int K = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2*K-1:0]   a_i,
  input  logic [2*K-1:0]   b_i,
  output logic             valid_o,
  output logic [2*K+1:0]   sum_o
);
  localparam int ND = K + 1;

  logic           v1, v2;
  logic [2*K+1:0] x1, w1, x2, w2;

  sdadd_split #(.K(K)) u_split (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i),
    .valid_o(v1), .xfer_o(x1), .intr_o(w1)
  );

  sdadd_merge #(.K(K)) u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v1),
    .xfer_i(x1), .intr_i(w1),
    .valid_o(v2), .xfer_o(x2), .intr_o(w2)
  );

  sdadd_join #(.K(K)) u_join (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v2),
    .xfer_i(x2), .intr_i(w2),
    .valid_o(valid_o), .sum_o(sum_o)
  );

  // cycles since reset, saturating, so the latency check never reaches before reset
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3))); // R3

  for (genvar i = 0; i < ND; i++) begin : g_chk
    AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> sum_o[2*i+:2] != 2'b10); // R5
  end
endmodule

// File: tb/sdadd_carry_free_test.sv
`timescale 1ns/1ps
module sdadd_carry_free_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // narrow instance, K=4
  logic        v4 = 1'b0;
  logic [7:0]  a4 = '0, b4 = '0;
  logic        vo4;
  logic [9:0]  s4;
  // wide instance, K=16
  logic        v16 = 1'b0;
  logic [31:0] a16 = '0, b16 = '0;
  logic        vo16;
  logic [33:0] s16;

  sdadd_carry_free #(.K(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v4), .a_i(a4), .b_i(b4),
    .valid_o(vo4), .sum_o(s4)
  );
  sdadd_carry_free #(.K(16)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v16), .a_i(a16), .b_i(b16),
    .valid_o(vo16), .sum_o(s16)
  );

  int n_chk = 0;
  int n_fail = 0;

  function automatic int dec(logic [63:0] v, int nd);
    int acc = 0;
    for (int i = nd - 1; i >= 0; i--) begin
      acc = acc * 2;
      if (v[2*i+:2] == 2'b01) acc = acc + 1;
      else if (v[2*i+:2] == 2'b11) acc = acc - 1;
    end
    return acc;
  endfunction

  function automatic int bad_codes(logic [63:0] v, int nd);
    int c = 0;
    for (int i = 0; i < nd; i++) if (v[2*i+:2] == 2'b10) c++;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] k4_operand(int x);
    logic [7:0] r;
    int y = x;
    for (int i = 0; i < 4; i++) begin
      case (y % 3)
        0:       r[2*i+:2] = 2'b00;
        1:       r[2*i+:2] = 2'b01;
        default: r[2*i+:2] = 2'b11;
      endcase
      y = y / 3;
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd16();
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      case ($urandom_range(0, 2))
        0:       r[2*i+:2] = 2'b00;
        1:       r[2*i+:2] = 2'b01;
        default: r[2*i+:2] = 2'b11;
      endcase
    end
    return r;
  endfunction

  task automatic t_reset();
    chk(vo4 == 1'b0, "R1 valid_o K=4", int'(vo4), 0);
    chk(s4 == '0, "R1 sum_o K=4", int'(s4), 0);
    chk(vo16 == 1'b0, "R1 valid_o K=16", int'(vo16), 0);
    chk(s16 == '0, "R1 sum_o K=16", int'(s16[31:0]), 0);
  endtask

  // all pairs back to back; result of pair c-3 checked while pair c enters
  task automatic t_exhaustive_k4();
    int ev[4] = '{0, 0, 0, 0};
    bit vv[4] = '{0, 0, 0, 0};
    int n = 81 * 81;
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      chk(vo4 == vv[(c + 1) & 3], "R3 R4 valid_o streaming K=4", int'(vo4), int'(vv[(c + 1) & 3]));
      if (vv[(c + 1) & 3]) begin
        chk(dec(64'(s4), 5) == ev[(c + 1) & 3], "R2 R4 sum value K=4", dec(64'(s4), 5), ev[(c + 1) & 3]);
        chk(bad_codes(64'(s4), 5) == 0, "R5 R7 output codes K=4", bad_codes(64'(s4), 5), 0);
      end
      if (c < n) begin
        a4 = k4_operand(c / 81);
        b4 = k4_operand(c % 81);
        v4 = 1'b1;
        ev[c & 3] = dec(64'(a4), 4) + dec(64'(b4), 4);
        vv[c & 3] = 1'b1;
      end else begin
        v4 = 1'b0;
        vv[c & 3] = 1'b0;
      end
    end
  endtask

  // random pairs with random idle gaps
  task automatic t_random_k16(int n);
    int ev[4] = '{0, 0, 0, 0};
    bit vv[4] = '{0, 0, 0, 0};
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      chk(vo16 == vv[(c + 1) & 3], "R3 valid_o delay K=16", int'(vo16), int'(vv[(c + 1) & 3]));
      if (vv[(c + 1) & 3])
        chk(dec(64'(s16), 17) == ev[(c + 1) & 3], "R2 sum value K=16", dec(64'(s16), 17), ev[(c + 1) & 3]);
      a16 = rnd16();
      b16 = rnd16();
      v16 = (c < n) && ($urandom_range(0, 3) != 0);
      vv[c & 3] = v16;
      ev[c & 3] = dec(64'(a16), 16) + dec(64'(b16), 16);
    end
    v16 = 1'b0;
  endtask

  task automatic one_k16(logic [31:0] a, logic [31:0] b, string req);
    int exp;
    @(negedge clk);
    a16 = a; b16 = b; v16 = 1'b1;
    exp = dec(64'(a), 16) + dec(64'(b), 16);
    @(negedge clk);
    v16 = 1'b0;
    repeat (2) @(negedge clk);
    chk(vo16 == 1'b1, req, int'(vo16), 1);
    chk(dec(64'(s16), 17) == exp, req, dec(64'(s16), 17), exp);
  endtask

  task automatic t_extremes();
    one_k16({16{2'b01}}, {16{2'b01}}, "R2 R6 max plus max");
    one_k16({16{2'b11}}, {16{2'b11}}, "R2 R6 min plus min");
    one_k16({16{2'b01}}, {16{2'b11}}, "R2 max plus min");
    one_k16({8{2'b01, 2'b11}}, {8{2'b11, 2'b01}}, "R2 alternating digits");
    one_k16({2'b01, {15{2'b11}}}, {16{2'b00}}, "R2 plus zero");
  endtask

  task automatic t_bad_code();
    @(negedge clk);
    a4 = {4{2'b10}}; b4 = 8'b01_11_00_01; v4 = 1'b1;
    @(negedge clk);
    v4 = 1'b0;
    repeat (2) @(negedge clk);
    chk(dec(64'(s4), 5) == dec(64'(8'b01_11_00_01), 4), "R5 input code 10 as zero",
        dec(64'(s4), 5), dec(64'(8'b01_11_00_01), 4));
  endtask

  task automatic t_hold();
    logic [9:0] held;
    @(negedge clk);
    a4 = 8'b01_01_01_01; b4 = 8'b01_00_11_01; v4 = 1'b1;
    @(negedge clk);
    v4 = 1'b0;
    repeat (2) @(negedge clk);
    held = s4;
    chk(dec(64'(s4), 5) == 15 + 7, "R8 result before idle", dec(64'(s4), 5), 22);
    for (int c = 0; c < 6; c++) begin
      a4 = k4_operand(c * 13);
      b4 = k4_operand(80 - c * 7);
      @(negedge clk);
      chk(s4 == held, "R8 sum_o held while idle", int'(s4), int'(held));
      chk(vo4 == 1'b0, "R8 valid_o low while idle", int'(vo4), 0);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_exhaustive_k4();
    t_random_k16(2000);
    t_extremes();
    t_bad_code();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule